// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two eight-bit buses, called A and B, and can move data across in either direction. Each bus has its own storage register. A register loads the value on its own bus when that side's capture strobe rises. One direction input and one active-low enable decide which bus, if any, is driven. A per-direction select then chooses what the driven bus carries: either the live value on the opposite bus or the contents of the opposite side's register.

The pads are not part of the block. Each bus appears as three signals: a data-in vector, a data-out vector and one output-enable bit. The capture strobes are plain level inputs. They are synchronised into one system clock and turned into a single-cycle load pulse on each rising transition. The registers keep loading whatever the enable and direction inputs say. The output path is purely combinational from the selects, the live inputs and the registers.

Top module: `regbus_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both storage registers. After reset, a stored-mode transfer in either direction drives all zeros.
- R2: The A register loads `a_in` on a rising transition of `a_cap`. If `a_cap` rises between clock edges, the new value becomes visible after the third following rising edge of `clk`, and not after the first or second (two synchroniser stages plus one load). `a_in` must be held from the strobe's rise through that edge.
- R3: The B register loads `b_in` on a rising transition of `b_cap`, with the same three-edge latency and the same hold rule.
- R4: Captures happen even while outputs are disabled (`oe_n` high, or the direction pointing away). A value captured this way can be read out later in stored mode.
- R5: With `oe_n` high, `a_oe` and `b_oe` are both 0 and `a_out` and `b_out` are both all zeros.
- R6: With `oe_n` low, `dir_ab` = 1 makes B the driven side (`b_oe` = 1, `a_oe` = 0, `a_out` = 0). `dir_ab` = 0 makes A the driven side (`a_oe` = 1, `b_oe` = 0, `b_out` = 0). The two enables are never both 1.
- R7: While B is driven and `sel_ab` = 0, `b_out` equals `a_in` in the same cycle.
- R8: While B is driven and `sel_ab` = 1, `b_out` equals the A register. This includes a value loaded at the immediately preceding clock edge.
- R9: While A is driven, `sel_ba` = 0 gives `a_out` = `b_in`, and `sel_ba` = 1 gives `a_out` = the B register.
- R10: A strobe held high loads exactly once. A later change of the bus data does not alter the register until the strobe falls and rises again.
- R11: A change of `sel_ab` or `sel_ba` changes the driven output without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_cap | input | 1 | A-side capture strobe (level, rising transition loads) |
| b_cap | input | 1 | B-side capture strobe |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir_ab | input | 1 | 1: drive B from A side; 0: drive A from B side |
| sel_ab | input | 1 | B source: 0 live A bus, 1 A register |
| sel_ba | input | 1 | A source: 0 live B bus, 1 B register |
| a_in | input | 8 | A bus data in |
| a_out | output | 8 | A bus data out, zero when not driven |
| a_oe | output | 1 | A bus output enable |
| b_in | input | 8 | B bus data in |
| b_out | output | 8 | B bus data out, zero when not driven |
| b_oe | output | 1 | B bus output enable |

## Verification
The output enables and the output data are combinational. They are due in the same cycle as the inputs, so the bench drives on the falling edge and compares a few nanoseconds later, before any rising edge can intervene. A register load is due exactly three rising edges after its strobe rises. For each pending strobe the bench keeps a countdown that it decrements on every rising edge, and it updates its model register only when the countdown expires. It also compares just before that edge, so both an early load and a late load are caught. While a load is pending, random stimulus keeps the strobe and the captured bus steady, which keeps the three-edge window unambiguous.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef struct packed {
    logic a_drv;
    logic b_drv;
  } drive_t;

  // Enable decode: an active-low master enable, then the direction picks one side
  function automatic drive_t decode_drive(input logic oe_n, input logic dir_ab);
    drive_t d;
    d.b_drv = !oe_n && dir_ab;
    d.a_drv = !oe_n && !dir_ab;
    return d;
  endfunction

  // The source choice for one direction: 1 takes the stored register
  function automatic logic pick_stored(input logic sel);
    return sel;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= lvl;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], lvl};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[LAST];
  end

  assign rise = chain[LAST] && !prev;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R10

endmodule

// File: rtl/side_store.sv
module side_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> q == '0); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R10

endmodule

// File: rtl/dir_mux.sv
module dir_mux #(
  parameter int WIDTH = 8
) (
  input  logic             drive,
  input  logic             use_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] dout
);
  always_comb begin
    dout = '0;
    if (drive) dout = use_stored ? stored : live;
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_cap,
  input  logic             b_cap,
  input  logic             oe_n,
  input  logic             dir_ab,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  import regbus_pkg::*;

  // Internal events brought out by name
  logic             a_load, b_load;
  logic [WIDTH-1:0] a_reg, b_reg;
  drive_t           drv;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst(rst), .lvl(a_cap), .rise(a_load));
  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .lvl(b_cap), .rise(b_load));

  side_store #(.WIDTH(WIDTH)) u_store_a (
    .clk(clk), .rst(rst), .load(a_load), .d(a_in), .q(a_reg));
  side_store #(.WIDTH(WIDTH)) u_store_b (
    .clk(clk), .rst(rst), .load(b_load), .d(b_in), .q(b_reg));

  assign drv  = decode_drive(oe_n, dir_ab);
  assign a_oe = drv.a_drv;
  assign b_oe = drv.b_drv;

  dir_mux #(.WIDTH(WIDTH)) u_mux_ab (
    .drive(drv.b_drv), .use_stored(pick_stored(sel_ab)),
    .live(a_in), .stored(a_reg), .dout(b_out));
  dir_mux #(.WIDTH(WIDTH)) u_mux_ba (
    .drive(drv.a_drv), .use_stored(pick_stored(sel_ba)),
    .live(b_in), .stored(b_reg), .dout(a_out));

  AST_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0)); // R5
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe)); // R6
  AST_FRESH_AB: assert property (@(posedge clk) disable iff (rst)
    (b_oe && sel_ab && $past(a_load)) |-> b_out == $past(a_in)); // R8
  AST_FRESH_BA: assert property (@(posedge clk) disable iff (rst)
    (a_oe && sel_ba && $past(b_load)) |-> a_out == $past(b_in)); // R9

endmodule

// File: tb/regbus_xcvr_bench.sv
`timescale 1ns/1ps
module regbus_xcvr_bench;
  localparam int W = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_cap = 0, b_cap = 0, oe_n = 1, dir_ab = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0, fails = 0;
  int a_due = 0, b_due = 0;
  logic [W-1:0] m_a = '0, m_b = '0;

  always #10 clk = ~clk;

  regbus_xcvr u_regbus_xcvr (
    .clk(clk), .rst(rst), .a_cap(a_cap), .b_cap(b_cap), .oe_n(oe_n),
    .dir_ab(dir_ab), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  function automatic logic [W-1:0] want_b();
    if (oe_n || !dir_ab) return '0;
    return sel_ab ? m_a : a_in;
  endfunction

  function automatic logic [W-1:0] want_a();
    if (oe_n || dir_ab) return '0;
    return sel_ba ? m_b : b_in;
  endfunction

  function automatic logic [1:0] want_oe();
    return {~oe_n & ~dir_ab, ~oe_n & dir_ab};
  endfunction

  task automatic check8(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check8(tag, {6'd0, a_oe, b_oe}, {6'd0, want_oe()});
    check8(tag, a_out, want_a());
    check8(tag, b_out, want_b());
  endtask

  // one rising edge with the model's load countdowns, then back to the falling edge
  task automatic tick();
    @(posedge clk);
    if (a_due > 0) begin a_due--; if (a_due == 0) m_a = a_in; end
    if (b_due > 0) begin b_due--; if (b_due == 0) m_b = b_in; end
    @(negedge clk);
  endtask

  task automatic set_a_cap(input logic v);
    if (v && !a_cap) a_due = LAT;
    a_cap = v;
  endtask

  task automatic set_b_cap(input logic v);
    if (v && !b_cap) b_due = LAT;
    b_cap = v;
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: registers start cleared
    oe_n = 0; dir_ab = 1; sel_ab = 1; a_in = 8'hFF; #5;
    check8("R1", b_out, 8'h00); check_all("R1");
    dir_ab = 0; sel_ba = 1; b_in = 8'hEE; #2;
    check8("R1", a_out, 8'h00); check_all("R1");
    tick();

    // R2: A capture due exactly at the third edge
    dir_ab = 1; sel_ab = 1; a_in = 8'hA5; set_a_cap(1); #5;
    check8("R2", b_out, 8'h00);
    tick(); #5; check8("R2", b_out, 8'h00);
    tick(); #5; check8("R2", b_out, 8'h00);
    tick(); #5; check8("R2", b_out, 8'hA5); check8("R8", b_out, 8'hA5);

    // R10: strobe held high, bus changes, no second load
    a_in = 8'h3C; tick(); tick(); tick(); tick(); #5;
    check8("R10", b_out, 8'hA5);
    set_a_cap(0); tick();

    // R7 / R11: select change without any clock edge
    a_in = 8'h11; sel_ab = 0; #3; check8("R7", b_out, 8'h11);
    sel_ab = 1; #3; check8("R11", b_out, 8'hA5);
    sel_ab = 0; #2; check8("R11", b_out, 8'h11);
    tick();

    // R4 / R5: capture while isolated, read later
    oe_n = 1; b_in = 8'h5A; set_b_cap(1); #5; check_all("R5");
    check8("R5", a_out | b_out, 8'h00);
    tick(); tick(); tick(); #5; check_all("R5");
    set_b_cap(0); b_in = 8'h77; tick();
    oe_n = 0; dir_ab = 0; sel_ba = 1; #5;
    check8("R4", a_out, 8'h5A); check8("R6", {6'd0, a_oe, b_oe}, 8'h02);
    sel_ba = 0; #2; check8("R9", a_out, 8'h77);
    check8("R6", b_out, 8'h00);

    // R3: B capture latency while A is driven in stored mode
    sel_ba = 1; b_in = 8'hC3; set_b_cap(1); tick(); tick(); #5;
    check8("R3", a_out, 8'h5A);
    tick(); #5; check8("R3", a_out, 8'hC3);
    set_b_cap(0); tick();

    // random mix (R6..R9)
    for (int i = 0; i < 3000; i++) begin
      oe_n   = ($urandom % 6) == 0;
      dir_ab = $urandom;
      sel_ab = $urandom;
      sel_ba = $urandom;
      if (a_due == 0) begin
        a_in = $urandom;
        if (($urandom % 3) == 0) set_a_cap(!a_cap);
      end
      if (b_due == 0) begin
        b_in = $urandom;
        if (($urandom % 3) == 0) set_b_cap(!b_cap);
      end
      #5;
      if (oe_n) check_all("R5");
      else if (dir_ab) check_all(sel_ab ? "R8" : "R7");
      else check_all("R9");
      tick();
    end

    // R1: reset again clears both registers
    rst = 1; tick(); rst = 0; m_a = '0; m_b = '0; a_due = 0; b_due = 0;
    a_cap = 0; b_cap = 0; tick();
    oe_n = 0; dir_ab = 1; sel_ab = 1; #5; check8("R1", b_out, 8'h00);
    dir_ab = 0; sel_ba = 1; #2; check8("R1", a_out, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule